// File: doc/BRIEF.md
# DMA Burst Register Window

This block gives a DMA engine access to a programmable run of neighbouring peripheral registers through one aliased bus address. A control register holds a base slot, a transfer count and an update-request enable bit. When an update event arrives with the enable set, the block raises a DMA request. The DMA engine then reads or writes the window address once for each transfer. The block sends each access to slot `(base + index) mod 32` and advances the index after every access. The index returns to zero once the programmed number of transfers has been made, so the next request starts again at the base.

The register file holds 32 half-word slots. Any slot can also be reached directly at its own address, and direct accesses have no effect on the burst. Some slots are reserved, as set by a parameter. Reserved slots hold no storage, so writes to them are accepted and dropped, and reads of them return zero. Writes can be byte-wide or half-word-wide through byte enables. Reads come back one cycle later on a registered data port.

Top module: `dma_burst_window`

## Requirements
- R1: After reset, every slot and the control register read as zero, `dma_req` is low and `bus_rvalid` is low.
- R2: Bus addresses 0 to 31 reach slots directly. Address 32 is the control register and address 33 is the window. Writes take effect at the clock edge. `bus_be[0]` enables bits 7:0 and `bus_be[1]` enables bits 15:8. A read is answered on the cycle after it is presented, with `bus_rvalid` high for exactly that cycle. Other addresses read as zero.
- R3: An access to the window reaches slot `(base + index) mod 32` and then advances the index by one. Addresses past slot 31 wrap around to slot 0.
- R4: Control bits 12:8 give the transfer count minus one. A value of n gives n+1 transfers, and values above 17 are treated as 17 (eighteen transfers). After the last transfer the index returns to zero.
- R5: Control bits 4:0 set the base slot, written under `bus_be[0]`. Bit 15 is the update-request enable, and bits 15 and 12:8 are written under `bus_be[1]`. The control register reads back in this same layout. Every write to it returns the index to zero.
- R6: Reserved slots (4, 8, 13 and 31 by default) read as zero. A write to one of them, whether direct or through the window, is accepted and has no effect. A window access to a reserved slot still advances the index.
- R7: When `upd_evt` is high and the enable bit is set, `dma_req` goes high on the next cycle. It stays high until a window access is made, and goes low on the cycle after that access. It never rises without a qualifying update event, and an update event on the same cycle as a window access takes priority.
- R8: Direct slot accesses and reads of the control register do not change the burst index.
- R9: With base 14 and count field 2, the first burst writes three words to slots 14, 15 and 16 in that order. The second burst writes the next three words to the same three slots in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access present this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Slot 0-31, control 32, window 33 |
| bus_be | input | 2 | Byte enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| upd_evt | input | 1 | Update event pulse |
| dma_req | output | 1 | DMA request for a burst |

## Verification
Every read result is due on the cycle after the access, and `dma_req` changes on the cycle after the update event or window access that causes it. Writes show up in the next read of the slot they targeted. The bench drives each access on a falling edge and releases it on the next falling edge. Read responses go into a queue when issued and are popped by a monitor on the falling edge where `bus_rvalid` should be high. Request checks are taken at the falling edge right after the stimulus. Slot contents, which give the burst order, are checked afterwards through direct reads.

// File: rtl/dbw_pkg.sv
package dbw_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_SLOT,
        OP_CTRL,
        OP_WIN,
        OP_HOLE
    } bus_op_e;

    localparam int CTRL_LEN_LSB = 8;

endpackage

// File: rtl/dbw_index.sv
module dbw_index #(
    parameter int IDX_W     = 5,
    parameter int LEN_CLAMP = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [IDX_W-1:0] len,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] CLAMP = IDX_W'(LEN_CLAMP);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } idx_state_t;

    idx_state_t st_d, st_q;
    logic [IDX_W-1:0] last;

    always_comb begin
        last = (len > CLAMP) ? CLAMP : len;
        st_d = st_q;
        if (clear) begin
            st_d.idx = '0;
        end else if (step) begin
            st_d.idx = (st_q.idx >= last) ? '0 : st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx = st_q.idx;

endmodule

// File: rtl/dbw_req.sv
module dbw_req (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic take,
    output logic req
);
    typedef struct packed {
        logic pend;
    } req_state_t;

    req_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire)      st_d.pend = 1'b1;
        else if (take) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req = st_q.pend;

endmodule

// File: rtl/dbw_regfile.sv
module dbw_regfile #(
    parameter int DATA_W  = 16,
    parameter int SLOT_AW = 5,
    parameter logic [(1<<SLOT_AW)-1:0] RSVD_MASK = 32'h8000_2110
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SLOT_AW-1:0]    slot,
    input  logic [DATA_W/8-1:0]   wr_be,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W-1:0]     rd_word
);
    localparam int NUM_SLOTS = 1 << SLOT_AW;
    localparam int BE_W      = DATA_W / 8;

    logic [DATA_W-1:0] slot_val [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        if (RSVD_MASK[g]) begin : g_rsvd
            assign slot_val[g] = '0;
        end else begin : g_cell
            logic [DATA_W-1:0] cell_d, cell_q;

            always_comb begin
                cell_d = cell_q;
                if (wr_en && slot == SLOT_AW'(g)) begin
                    for (int b = 0; b < BE_W; b++) begin
                        if (wr_be[b]) cell_d[b*8 +: 8] = wr_data[b*8 +: 8];
                    end
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cell_q <= '0;
                else        cell_q <= cell_d;
            end

            assign slot_val[g] = cell_q;
        end
    end

    assign rd_word = slot_val[slot];

endmodule

// File: rtl/dma_burst_window.sv
module dma_burst_window #(
    parameter int DATA_W    = 16,
    parameter int SLOT_AW   = 5,
    parameter int LEN_CLAMP = 17,
    parameter logic [(1<<SLOT_AW)-1:0] RSVD_MASK = 32'h8000_2110
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [SLOT_AW:0]      bus_addr,
    input  logic [DATA_W/8-1:0]   bus_be,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  bus_rvalid,
    input  logic                  upd_evt,
    output logic                  dma_req
);
    import dbw_pkg::*;

    localparam int NUM_SLOTS = 1 << SLOT_AW;
    localparam int ADDR_W    = SLOT_AW + 1;
    localparam int BE_W      = DATA_W / 8;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_SLOTS);
    localparam logic [ADDR_W-1:0] WIN_ADDR  = ADDR_W'(NUM_SLOTS + 1);

    typedef struct packed {
        logic [SLOT_AW-1:0] base;
        logic [SLOT_AW-1:0] len;
        logic               en;
        logic [DATA_W-1:0]  rdata;
        logic               rvalid;
    } top_state_t;

    top_state_t st_d, st_q;

    bus_op_e            op;
    logic               win_acc, dir_acc, ctrl_wr, upd_fire, rf_wr;
    logic [SLOT_AW-1:0] burst_idx, target, rf_slot;
    logic [DATA_W-1:0]  rf_word, ctrl_word;

    // address decode
    always_comb begin
        op = OP_IDLE;
        if (bus_sel) begin
            if (!bus_addr[SLOT_AW])      op = OP_SLOT;
            else if (bus_addr == CTRL_ADDR) op = OP_CTRL;
            else if (bus_addr == WIN_ADDR)  op = OP_WIN;
            else                         op = OP_HOLE;
        end
    end

    assign win_acc  = (op == OP_WIN);
    assign dir_acc  = (op == OP_SLOT);
    assign ctrl_wr  = (op == OP_CTRL) && bus_wr;
    assign upd_fire = upd_evt && st_q.en;
    assign target   = st_q.base + burst_idx;
    assign rf_slot  = win_acc ? target : bus_addr[SLOT_AW-1:0];
    assign rf_wr    = (win_acc || dir_acc) && bus_wr;

    always_comb begin
        ctrl_word = '0;
        ctrl_word[SLOT_AW-1:0]             = st_q.base;
        ctrl_word[CTRL_LEN_LSB +: SLOT_AW] = st_q.len;
        ctrl_word[DATA_W-1]                = st_q.en;
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = bus_sel && !bus_wr;
        if (bus_sel && !bus_wr) begin
            case (op)
                OP_SLOT, OP_WIN: st_d.rdata = rf_word;
                OP_CTRL:         st_d.rdata = ctrl_word;
                default:         st_d.rdata = '0;
            endcase
        end
        if (ctrl_wr) begin
            if (bus_be[0]) st_d.base = bus_wdata[SLOT_AW-1:0];
            if (bus_be[BE_W-1]) begin
                st_d.len = bus_wdata[CTRL_LEN_LSB +: SLOT_AW];
                st_d.en  = bus_wdata[DATA_W-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign bus_rvalid = st_q.rvalid;

    dbw_regfile #(
        .DATA_W   (DATA_W),
        .SLOT_AW  (SLOT_AW),
        .RSVD_MASK(RSVD_MASK)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (rf_wr),
        .slot   (rf_slot),
        .wr_be  (bus_be),
        .wr_data(bus_wdata),
        .rd_word(rf_word)
    );

    dbw_index #(
        .IDX_W    (SLOT_AW),
        .LEN_CLAMP(LEN_CLAMP)
    ) u_index (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(ctrl_wr),
        .step (win_acc),
        .len  (st_q.len),
        .idx  (burst_idx)
    );

    dbw_req u_req (
        .clk  (clk),
        .rst_n(rst_n),
        .fire (upd_fire),
        .take (win_acc),
        .req  (dma_req)
    );

endmodule

// File: rtl/dbw_checker.sv
module dbw_checker #(
    parameter int IDX_W     = 5,
    parameter int LEN_CLAMP = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic             bus_rvalid,
    input logic             dma_req,
    input logic             win_acc,
    input logic             dir_acc,
    input logic             ctrl_wr,
    input logic             upd_fire,
    input logic [IDX_W-1:0] burst_idx
);
    assert_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);

    assert_rvalid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> !bus_rvalid);

    assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        burst_idx <= IDX_W'(LEN_CLAMP));

    assert_ctrl_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (burst_idx == '0));

    assert_req_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_fire |=> dma_req);

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !win_acc) |=> dma_req);

    assert_req_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_acc && !upd_fire) |=> !dma_req);

    assert_req_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req && !upd_fire) |=> !dma_req);

    assert_direct_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dir_acc |=> $stable(burst_idx));

endmodule

bind dma_burst_window dbw_checker #(
    .IDX_W    (SLOT_AW),
    .LEN_CLAMP(LEN_CLAMP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rvalid(bus_rvalid),
    .dma_req   (dma_req),
    .win_acc   (win_acc),
    .dir_acc   (dir_acc),
    .ctrl_wr   (ctrl_wr),
    .upd_fire  (upd_fire),
    .burst_idx (burst_idx)
);

// File: tb/dma_burst_window_test.sv
`timescale 1ns/1ps
module dma_burst_window_test;
    localparam logic [31:0] RSVD = 32'h8000_2110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_rvalid;
    logic        upd_evt = 1'b0;
    logic        dma_req;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [15:0] exp_q [$];
    string       tag_q [$];

    // bench model built from the requirements
    logic [15:0] m_slot [32];
    logic [4:0]  m_base = '0;
    logic [4:0]  m_len = '0;
    logic        m_en = 1'b0;
    logic [4:0]  m_idx = '0;

    always #2 clk = ~clk;

    dma_burst_window uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .upd_evt(upd_evt), .dma_req(dma_req)
    );

    function automatic logic [4:0] m_target();
        return m_base + m_idx;
    endfunction

    function automatic void m_step();
        logic [4:0] last;
        last = (m_len > 5'd17) ? 5'd17 : m_len;
        m_idx = (m_idx == last) ? 5'd0 : m_idx + 5'd1;
    endfunction

    task automatic drive(input logic wr, input logic [5:0] a,
                         input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr_slot(input int a, input logic [15:0] d, input logic [1:0] be);
        if (!RSVD[a]) begin
            if (be[0]) m_slot[a][7:0]  = d[7:0];
            if (be[1]) m_slot[a][15:8] = d[15:8];
        end
        drive(1'b1, 6'(a), be, d);
    endtask

    task automatic rd_slot(input int a, input string tag);
        exp_q.push_back((a < 32) ? m_slot[a] : 16'h0);
        tag_q.push_back(tag);
        drive(1'b0, 6'(a), 2'b00, 16'h0);
    endtask

    task automatic wr_ctrl(input logic [4:0] b, input logic [4:0] l, input logic e);
        m_base = b; m_len = l; m_en = e; m_idx = '0;
        drive(1'b1, 6'd32, 2'b11, {e, 2'b00, l, 3'b000, b});
    endtask

    task automatic rd_ctrl(input string tag);
        exp_q.push_back({m_en, 2'b00, m_len, 3'b000, m_base});
        tag_q.push_back(tag);
        drive(1'b0, 6'd32, 2'b00, 16'h0);
    endtask

    task automatic win_wr(input logic [15:0] d);
        logic [4:0] t;
        t = m_target();
        if (!RSVD[t]) m_slot[t] = d;
        m_step();
        drive(1'b1, 6'd33, 2'b11, d);
    endtask

    task automatic win_rd(input string tag);
        exp_q.push_back(m_slot[m_target()]);
        tag_q.push_back(tag);
        m_step();
        drive(1'b0, 6'd33, 2'b00, 16'h0);
    endtask

    task automatic pulse_upd();
        @(negedge clk);
        upd_evt = 1'b1;
        @(negedge clk);
        upd_evt = 1'b0;
    endtask

    task automatic check_req(input logic e, input string tag);
        nvec++;
        if (dma_req !== e) begin
            nfail++;
            $display("FAIL %s dma_req actual=%b expected=%b", tag, dma_req, e);
        end
    endtask

    // monitor: pops expected reads as responses appear
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            nvec++;
            if (exp_q.size() == 0) begin
                nfail++;
                $display("FAIL R2 unexpected response actual=%h expected=none", bus_rdata);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    nfail++;
                    $display("FAIL %s read actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) m_slot[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_req(1'b0, "R1");
        rd_ctrl("R1");
        rd_slot(0, "R1");
        rd_slot(15, "R1");

        // R2 direct access and byte enables
        wr_slot(1, 16'hBEEF, 2'b11);
        rd_slot(1, "R2");
        wr_slot(1, 16'h0012, 2'b01);
        rd_slot(1, "R2");
        wr_slot(1, 16'h3400, 2'b10);
        rd_slot(1, "R2");
        rd_slot(40, "R2");

        // R6 reserved direct write
        wr_slot(4, 16'hFFFF, 2'b11);
        rd_slot(4, "R6");

        // R7 update with enable clear
        wr_ctrl(5'd14, 5'd2, 1'b0);
        pulse_upd();
        check_req(1'b0, "R7");

        // R9 / R5 compare example
        wr_ctrl(5'd14, 5'd2, 1'b1);
        rd_ctrl("R5");
        pulse_upd();
        check_req(1'b1, "R7");
        rd_slot(2, "R7");
        check_req(1'b1, "R7");
        win_wr(16'hD001);
        check_req(1'b0, "R7");
        win_wr(16'hD002);
        win_wr(16'hD003);
        check_req(1'b0, "R7");
        rd_slot(14, "R9");
        rd_slot(15, "R9");
        rd_slot(16, "R9");
        pulse_upd();
        check_req(1'b1, "R7");
        win_wr(16'hD004);
        win_wr(16'hD005);
        win_wr(16'hD006);
        rd_slot(14, "R9");
        rd_slot(15, "R9");
        rd_slot(16, "R9");
        rd_slot(17, "R9");

        // R8 direct accesses keep the index
        win_wr(16'hE001);
        wr_slot(20, 16'h2020, 2'b11);
        rd_slot(20, "R8");
        rd_ctrl("R8");
        win_wr(16'hE002);
        rd_slot(14, "R8");
        rd_slot(15, "R8");

        // R5 control write clears the index
        wr_ctrl(5'd14, 5'd2, 1'b0);
        win_wr(16'hF001);
        rd_slot(14, "R5");
        rd_slot(15, "R5");

        // R3 wrap past slot 31, R6 reserved through the window
        wr_ctrl(5'd30, 5'd3, 1'b0);
        win_wr(16'hA030);
        win_wr(16'hA031);
        win_wr(16'hA000);
        win_wr(16'hA001);
        rd_slot(30, "R3");
        rd_slot(31, "R6");
        rd_slot(0, "R3");
        rd_slot(1, "R3");
        win_rd("R3");
        win_rd("R6");
        win_rd("R3");
        win_rd("R3");
        win_rd("R3");

        // R4 single transfer encoding
        wr_ctrl(5'd20, 5'd0, 1'b0);
        win_wr(16'h1111);
        win_wr(16'h2222);
        rd_slot(20, "R4");
        rd_slot(21, "R4");

        // R4 clamp to eighteen transfers
        wr_ctrl(5'd0, 5'd31, 1'b0);
        for (int i = 0; i < 18; i++) win_wr(16'h0100 + 16'(i));
        win_wr(16'hAAAA);
        for (int i = 0; i < 19; i++) rd_slot(i, "R4");

        repeat (3) @(negedge clk);
        nvec++;
        if (exp_q.size() != 0) begin
            nfail++;
            $display("FAIL R2 missing responses actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule